// File: doc/BRIEF.md
# Serial Debug Memory Access Bridge

This block sits behind a standard IEEE 1149.1 TAP controller, which supplies the state strobes for the instruction and data register paths. The block holds a 5-bit instruction register and decodes a set of private instructions. These instructions give a serial debug host byte-wide access to an internal register space and to two flash windows. The data registers it offers are a 32-bit identification word, an 8-bit address register, an 8-bit read register and an 8-bit write register. Any opcode it does not recognise selects a 1-bit bypass register.

A read is requested in the Capture-DR cycle of the read register. The returned byte is then shifted out on `tdo`. A write is requested in the Update-DR cycle of the write register, using the byte that was just shifted in. Each access advances the address register by one, so a host can stream consecutive bytes. Three page states select the upper two bits of the 10-bit effective address:
- `PG_BASE` gives 000h–0FFh.
- `PG_CFG` gives 200h–2FFh.
- `PG_USER` gives 300h–3FFh.

The page transitions are:
- `PG_BASE`→`PG_CFG` on the flash-page enable.
- `PG_CFG`→`PG_USER` on the user-page enable.
- `PG_USER`→`PG_CFG` on the user-page disable.
- `PG_CFG`/`PG_USER`→`PG_BASE` on the flash-page disable.
- Every other instruction holds the state.

Two further instructions each produce a one-cycle pulse: one for a soft reboot and one for a fault-log save.

Top module: `jbr_bridge`

## Requirements
- R1: While `trst_n` is low and after its release: the address register is 0, the page is `PG_BASE` (`mem_addr`=0), the instruction is bypass (5'h1F), and `mem_rd`, `mem_wr`, `reboot_pulse` and `save_pulse` are all 0.
- R2: Instruction path behaviour:
  - Capture-IR loads 5'b00001.
  - Shift-IR shifts toward `tdo` LSB first, with `tdi` entering at bit 4.
  - Update-IR latches the opcode.
  - The opcodes are: identification 5'h08, address 5'h0A, read 5'h0B, write 5'h0C, reboot 5'h0D, save 5'h0E, flash-page enable 5'h10, flash-page disable 5'h11, user-page enable 5'h12, user-page disable 5'h13, bypass 5'h1F.
  - Any other opcode selects the 1-bit bypass register. That register captures 0 and delays `tdi` by one shift.
- R3: Under the identification opcode, Capture-DR loads a 32-bit word that is shifted out LSB first:
  - bits 7:0 = `user_id`
  - bits 14:8 = `slave_id`
  - bits 31:15 = 0
- R4: Under the address opcode, Capture-DR loads the current 8-bit address, and Update-DR loads the 8 bits that were shifted in.
- R5: Under the read opcode, `mem_rd` is high for exactly the Capture-DR cycle, with `mem_addr` holding the current effective address. The `mem_rdata` of that cycle is then shifted out LSB first.
- R6: Under the write opcode, `mem_wr` is high for exactly the Update-DR cycle. During that cycle `mem_wdata` holds the 8 bits shifted in and `mem_addr` holds the current effective address.
- R7: After each `mem_rd` or `mem_wr` cycle the address register increments by one, wrapping from FFh to 00h. The page bits are not affected.
- R8: The page state sets `mem_addr[9:8]`: `PG_BASE`=00, `PG_CFG`=10, `PG_USER`=11. It changes only on Update-IR, following the transitions above. The user-page enable is ignored in `PG_BASE`, and the user-page disable is ignored outside `PG_USER`.
- R9: `reboot_pulse` or `save_pulse` is high for exactly the one cycle after Update-IR latches the reboot or save opcode. The two pulses are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset |
| tdi | input | 1 | Serial data in |
| capture_ir | input | 1 | TAP is in Capture-IR |
| shift_ir | input | 1 | TAP is in Shift-IR |
| update_ir | input | 1 | TAP is in Update-IR |
| capture_dr | input | 1 | TAP is in Capture-DR |
| shift_dr | input | 1 | TAP is in Shift-DR |
| update_dr | input | 1 | TAP is in Update-DR |
| user_id | input | 8 | User ID for the identification word |
| slave_id | input | 7 | Bus slave ID for the identification word |
| mem_rdata | input | 8 | Read byte, valid in the `mem_rd` cycle |
| tdo | output | 1 | Serial data out |
| mem_addr | output | 10 | Effective address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write byte |
| reboot_pulse | output | 1 | Soft reboot request |
| save_pulse | output | 1 | Fault-log save request |

## Verification
Directed scans cover the corner cases:
- The instruction capture pattern.
- An unknown opcode, which must behave as bypass.
- The identification word, whose fields must come out in their stated positions.
- An address of FFh, which must wrap to 00h on the next access.
- A page walk that tries the illegal orders, such as the user-page enable from the base page. This separates a correct page machine from one that jumps straight to the user page.

Seeded random sequences then mix page changes, address loads, writes, reads, reboots and saves. Each access is compared against a bench model of the page and address. This shows whether the increment, the page prefix and the read-data capture stay consistent over long runs.

// File: rtl/jbr_pkg.sv
package jbr_pkg;
    localparam int IR_W = 5;

    localparam logic [IR_W-1:0] OP_UCODE  = 5'h08;
    localparam logic [IR_W-1:0] OP_ADDR   = 5'h0A;
    localparam logic [IR_W-1:0] OP_RD     = 5'h0B;
    localparam logic [IR_W-1:0] OP_WR     = 5'h0C;
    localparam logic [IR_W-1:0] OP_REBOOT = 5'h0D;
    localparam logic [IR_W-1:0] OP_SAVE   = 5'h0E;
    localparam logic [IR_W-1:0] OP_FL_ON  = 5'h10;
    localparam logic [IR_W-1:0] OP_FL_OFF = 5'h11;
    localparam logic [IR_W-1:0] OP_US_ON  = 5'h12;
    localparam logic [IR_W-1:0] OP_US_OFF = 5'h13;
    localparam logic [IR_W-1:0] OP_BYPASS = 5'h1F;
    localparam logic [IR_W-1:0] IR_CAPT   = 5'b00001;

    typedef enum logic [2:0] {
        SEL_BYP, SEL_UCODE, SEL_ADDR, SEL_RD, SEL_WR
    } sel_t;

    // encoding equals the effective-address prefix
    typedef enum logic [1:0] {
        PG_BASE = 2'b00,
        PG_CFG  = 2'b10,
        PG_USER = 2'b11
    } page_t;
endpackage

// File: rtl/jbr_ir.sv
module jbr_ir
    import jbr_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  logic            capture_ir,
    input  logic            shift_ir,
    input  logic            update_ir,
    output logic            ir_lsb,
    output logic [IR_W-1:0] ir_shift,
    output sel_t            sel,
    output logic            reboot_pulse,
    output logic            save_pulse
);
    logic [IR_W-1:0] ir_sh;
    logic [IR_W-1:0] ir_q;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir_sh        <= IR_CAPT;
            ir_q         <= OP_BYPASS;
            reboot_pulse <= 1'b0;
            save_pulse   <= 1'b0;
        end else begin
            if (capture_ir)
                ir_sh <= IR_CAPT;
            else if (shift_ir)
                ir_sh <= {tdi, ir_sh[IR_W-1:1]};
            if (update_ir)
                ir_q <= ir_sh;
            reboot_pulse <= update_ir && (ir_sh == OP_REBOOT);
            save_pulse   <= update_ir && (ir_sh == OP_SAVE);
        end
    end

    always_comb begin
        unique case (ir_q)
            OP_UCODE: sel = SEL_UCODE;
            OP_ADDR:  sel = SEL_ADDR;
            OP_RD:    sel = SEL_RD;
            OP_WR:    sel = SEL_WR;
            default:  sel = SEL_BYP;
        endcase
    end

    assign ir_lsb   = ir_sh[0];
    assign ir_shift = ir_sh;
endmodule

// File: rtl/jbr_page_fsm.sv
module jbr_page_fsm
    import jbr_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  logic            update_ir,
    input  logic [IR_W-1:0] op_in,
    output logic [1:0]      page_bits
);
    page_t state, state_nx;

    // state register
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)
            state <= PG_BASE;
        else
            state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        if (update_ir) begin
            unique case (state)
                PG_BASE: if (op_in == OP_FL_ON)  state_nx = PG_CFG;
                PG_CFG: begin
                    if (op_in == OP_US_ON)       state_nx = PG_USER;
                    else if (op_in == OP_FL_OFF) state_nx = PG_BASE;
                end
                PG_USER: begin
                    if (op_in == OP_US_OFF)      state_nx = PG_CFG;
                    else if (op_in == OP_FL_OFF) state_nx = PG_BASE;
                end
                default:                         state_nx = PG_BASE;
            endcase
        end
    end

    // outputs
    always_comb begin
        page_bits = state;
    end
endmodule

// File: rtl/jbr_dr.sv
module jbr_dr
    import jbr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int UC_W   = 32,
    parameter int ID_W   = 8,
    parameter int SLV_W  = 7
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tdi,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  sel_t              sel,
    input  logic [ID_W-1:0]   user_id,
    input  logic [SLV_W-1:0]  slave_id,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              dr_lsb,
    output logic [ADDR_W-1:0] addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata
);
    logic [UC_W-1:0] sh, sh_nx, ucode;

    always_comb begin
        ucode = '0;
        ucode[ID_W-1:0]      = user_id;
        ucode[ID_W +: SLV_W] = slave_id;
    end

    always_comb begin
        sh_nx = sh;
        if (capture_dr) begin
            unique case (sel)
                SEL_UCODE: sh_nx = ucode;
                SEL_ADDR:  sh_nx = UC_W'(addr);
                SEL_RD:    sh_nx = UC_W'(mem_rdata);
                default:   sh_nx = '0;
            endcase
        end else if (shift_dr) begin
            sh_nx = sh >> 1;
            unique case (sel)
                SEL_UCODE:     sh_nx[UC_W-1]   = tdi;
                SEL_ADDR:      sh_nx[ADDR_W-1] = tdi;
                SEL_RD, SEL_WR: sh_nx[DATA_W-1] = tdi;
                default:       sh_nx[0]        = tdi;
            endcase
        end
    end

    assign mem_rd    = capture_dr && (sel == SEL_RD);
    assign mem_wr    = update_dr && (sel == SEL_WR);
    assign mem_wdata = sh[DATA_W-1:0];
    assign dr_lsb    = sh[0];

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            sh   <= '0;
            addr <= '0;
        end else begin
            sh <= sh_nx;
            if (update_dr && sel == SEL_ADDR)
                addr <= sh[ADDR_W-1:0];
            else if (mem_rd || mem_wr)
                addr <= addr + 1'b1;
        end
    end
endmodule

// File: rtl/jbr_bridge.sv
module jbr_bridge
    import jbr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int UC_W   = 32,
    parameter int ID_W   = 8,
    parameter int SLV_W  = 7,
    localparam int EA_W  = ADDR_W + 2
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tdi,
    input  logic              capture_ir,
    input  logic              shift_ir,
    input  logic              update_ir,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic [ID_W-1:0]   user_id,
    input  logic [SLV_W-1:0]  slave_id,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              tdo,
    output logic [EA_W-1:0]   mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              reboot_pulse,
    output logic              save_pulse
);
    logic            ir_lsb, dr_lsb;
    logic [IR_W-1:0] ir_shift;
    sel_t            sel;
    logic [1:0]      page_bits;
    logic [ADDR_W-1:0] addr;

    jbr_ir u_ir (
        .tck(tck), .trst_n(trst_n), .tdi(tdi),
        .capture_ir(capture_ir), .shift_ir(shift_ir), .update_ir(update_ir),
        .ir_lsb(ir_lsb), .ir_shift(ir_shift), .sel(sel),
        .reboot_pulse(reboot_pulse), .save_pulse(save_pulse)
    );

    jbr_page_fsm u_page (
        .tck(tck), .trst_n(trst_n), .update_ir(update_ir),
        .op_in(ir_shift), .page_bits(page_bits)
    );

    jbr_dr #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .UC_W(UC_W),
        .ID_W(ID_W), .SLV_W(SLV_W)
    ) u_dr (
        .tck(tck), .trst_n(trst_n), .tdi(tdi),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .sel(sel), .user_id(user_id), .slave_id(slave_id),
        .mem_rdata(mem_rdata), .dr_lsb(dr_lsb), .addr(addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata)
    );

    assign mem_addr = {page_bits, addr};
    assign tdo      = shift_ir ? ir_lsb : dr_lsb;
endmodule

// File: rtl/jbr_bridge_chk.sv
module jbr_bridge_chk #(
    parameter int ADDR_W = 8
) (
    input logic              tck,
    input logic              trst_n,
    input logic              update_ir,
    input logic              capture_dr,
    input logic              update_dr,
    input logic [ADDR_W+1:0] mem_addr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              reboot_pulse,
    input logic              save_pulse
);
    p_strobe_excl_r5: assert property (@(posedge tck) disable iff (!trst_n)
        !(mem_rd && mem_wr));
    p_rd_gate_r5: assert property (@(posedge tck) disable iff (!trst_n)
        mem_rd |-> capture_dr);
    p_wr_gate_r6: assert property (@(posedge tck) disable iff (!trst_n)
        mem_wr |-> update_dr);
    p_rd_incr_r7: assert property (@(posedge tck) disable iff (!trst_n)
        mem_rd |=> mem_addr[ADDR_W-1:0] == $past(mem_addr[ADDR_W-1:0]) + 1'b1);
    p_wr_incr_r7: assert property (@(posedge tck) disable iff (!trst_n)
        mem_wr |=> mem_addr[ADDR_W-1:0] == $past(mem_addr[ADDR_W-1:0]) + 1'b1);
    p_page_legal_r8: assert property (@(posedge tck) disable iff (!trst_n)
        mem_addr[ADDR_W+1:ADDR_W] != 2'b01);
    p_page_hold_r8: assert property (@(posedge tck) disable iff (!trst_n)
        !update_ir |=> $stable(mem_addr[ADDR_W+1:ADDR_W]));
    p_reboot_once_r9: assert property (@(posedge tck) disable iff (!trst_n)
        reboot_pulse |=> !reboot_pulse);
    p_save_once_r9: assert property (@(posedge tck) disable iff (!trst_n)
        save_pulse |=> !save_pulse);
    p_save_src_r9: assert property (@(posedge tck) disable iff (!trst_n)
        save_pulse |-> $past(update_ir));
    p_pulse_excl_r9: assert property (@(posedge tck) disable iff (!trst_n)
        !(reboot_pulse && save_pulse));
endmodule

bind jbr_bridge jbr_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (
    .tck(tck), .trst_n(trst_n), .update_ir(update_ir),
    .capture_dr(capture_dr), .update_dr(update_dr),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .reboot_pulse(reboot_pulse), .save_pulse(save_pulse)
);

// File: tb/sim_jbr_bridge.sv
`timescale 1ns/1ps
module sim_jbr_bridge;
    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tdi = 1'b0;
    logic capture_ir = 0, shift_ir = 0, update_ir = 0;
    logic capture_dr = 0, shift_dr = 0, update_dr = 0;
    logic [7:0] user_id = 8'hA5;
    logic [6:0] slave_id = 7'h5B;
    logic [7:0] mem_rdata;
    logic tdo, mem_rd, mem_wr, reboot_pulse, save_pulse;
    logic [9:0] mem_addr;
    logic [7:0] mem_wdata;

    always #2.5 tck = ~tck;

    jbr_bridge u0 (.*);

    function automatic logic [7:0] mem_f(input logic [9:0] a);
        return (a[7:0] * 8'd3) ^ {a[9:8], 6'h11};
    endfunction
    assign mem_rdata = mem_f(mem_addr);

    function automatic logic [1:0] page_next(input logic [1:0] p, input logic [4:0] op);
        case (p)
            2'b00: return (op == 5'h10) ? 2'b10 : p;
            2'b10: return (op == 5'h12) ? 2'b11 : (op == 5'h11) ? 2'b00 : p;
            default: return (op == 5'h13) ? 2'b10 : (op == 5'h11) ? 2'b00 : p;
        endcase
    endfunction

    int n_chk = 0, n_bad = 0;
    int rd_cnt = 0, wr_cnt = 0, rb_cnt = 0, sv_cnt = 0;
    logic [9:0] rd_addr, wr_addr;
    logic [7:0] wr_data;
    logic [1:0] e_page = 2'b00;
    logic [7:0] e_addr = 8'h00;

    always begin
        @(negedge tck); #1;
        if (mem_rd) begin rd_cnt++; rd_addr = mem_addr; end
        if (mem_wr) begin wr_cnt++; wr_addr = mem_addr; wr_data = mem_wdata; end
        if (reboot_pulse) rb_cnt++;
        if (save_pulse) sv_cnt++;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ir_scan(input logic [4:0] op, output logic [4:0] cap);
        @(negedge tck); capture_ir = 1;
        @(negedge tck); capture_ir = 0; shift_ir = 1;
        for (int i = 0; i < 5; i++) begin
            tdi = op[i]; #1; cap[i] = tdo;
            @(negedge tck);
        end
        shift_ir = 0; update_ir = 1;
        @(negedge tck); update_ir = 0;
        @(negedge tck);
        e_page = page_next(e_page, op);
    endtask

    task automatic dr_scan(input int len, input logic [31:0] din, output logic [31:0] dout);
        @(negedge tck); capture_dr = 1;
        @(negedge tck); capture_dr = 0; shift_dr = 1;
        dout = '0;
        for (int i = 0; i < len; i++) begin
            tdi = din[i]; #1; dout[i] = tdo;
            @(negedge tck);
        end
        shift_dr = 0; update_dr = 1;
        @(negedge tck); update_dr = 0;
        @(negedge tck);
    endtask

    task automatic do_write(input logic [7:0] b);
        logic [4:0] c; logic [31:0] o; int w0;
        ir_scan(5'h0C, c);
        w0 = wr_cnt;
        dr_scan(8, {24'h0, b}, o);
        check(wr_cnt == w0 + 1, "R6 one write strobe", wr_cnt - w0, 1);
        check(wr_addr == {e_page, e_addr}, "R6 write address", wr_addr, {e_page, e_addr});
        check(wr_data == b, "R6 write data", wr_data, b);
        e_addr = e_addr + 8'd1;
    endtask

    task automatic do_read();
        logic [4:0] c; logic [31:0] o; int r0;
        ir_scan(5'h0B, c);
        r0 = rd_cnt;
        dr_scan(8, 32'h0, o);
        check(rd_cnt == r0 + 1, "R5 one read strobe", rd_cnt - r0, 1);
        check(rd_addr == {e_page, e_addr}, "R5/R7 read address", rd_addr, {e_page, e_addr});
        check(o[7:0] == mem_f({e_page, e_addr}), "R5 read data", o[7:0], mem_f({e_page, e_addr}));
        e_addr = e_addr + 8'd1;
    endtask

    task automatic load_addr(input logic [7:0] a);
        logic [4:0] c; logic [31:0] o;
        ir_scan(5'h0A, c);
        dr_scan(8, {24'h0, a}, o);
        check(o[7:0] == e_addr, "R4 address capture", o[7:0], e_addr);
        e_addr = a;
    endtask

    task automatic page_op(input logic [4:0] op);
        logic [4:0] c;
        ir_scan(op, c);
        check(mem_addr[9:8] == e_page, "R8 page bits", mem_addr[9:8], e_page);
    endtask

    initial begin : wd
        repeat (200000) @(posedge tck);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [4:0] c; logic [31:0] o; int k0;
        void'($urandom(32'd4242));
        repeat (3) @(negedge tck);
        #1;
        check(mem_addr == 10'h000, "R1 reset address", mem_addr, 0);
        check({mem_rd, mem_wr, reboot_pulse, save_pulse} == 4'b0, "R1 reset strobes",
              {mem_rd, mem_wr, reboot_pulse, save_pulse}, 0);
        trst_n = 1;
        @(negedge tck); #1;
        check(mem_addr == 10'h000, "R1 address after release", mem_addr, 0);
        // R1/R2: reset instruction is bypass
        dr_scan(2, 32'h1, o);
        check(o[1:0] == 2'b10, "R1 bypass after reset", o[1:0], 2'b10);
        // R2 capture pattern and unknown opcode
        ir_scan(5'h03, c);
        check(c == 5'b00001, "R2 IR capture pattern", c, 5'b00001);
        dr_scan(3, 32'h3, o);
        check(o[2:0] == 3'b110, "R2 unknown opcode bypass", o[2:0], 3'b110);
        // R3 identification
        ir_scan(5'h08, c);
        dr_scan(32, 32'h0, o);
        check(o == {17'h0, slave_id, user_id}, "R3 user code", o, {17'h0, slave_id, user_id});
        user_id = 8'h3C; slave_id = 7'h21;
        dr_scan(32, 32'h0, o);
        check(o == {17'h0, slave_id, user_id}, "R3 user code 2", o, {17'h0, slave_id, user_id});
        // R4 address register
        load_addr(8'h37);
        load_addr(8'hF0);
        // R6/R7 consecutive writes
        do_write(8'h5A);
        do_write(8'hC3);
        // R7 wrap
        load_addr(8'hFF);
        do_write(8'h81);
        check(e_addr == 8'h00 && mem_addr == 10'h000, "R7 wrap to zero", mem_addr, 0);
        do_read();
        // R8 page walk incl. ignored orders
        page_op(5'h12);
        check(mem_addr[9:8] == 2'b00, "R8 user enable ignored in base", mem_addr[9:8], 0);
        page_op(5'h10);
        check(mem_addr[9:8] == 2'b10, "R8 flash page", mem_addr[9:8], 2'b10);
        page_op(5'h13);
        check(mem_addr[9:8] == 2'b10, "R8 user disable ignored in cfg", mem_addr[9:8], 2'b10);
        page_op(5'h12);
        check(mem_addr[9:8] == 2'b11, "R8 user page", mem_addr[9:8], 2'b11);
        do_read();
        page_op(5'h13);
        check(mem_addr[9:8] == 2'b10, "R8 back to cfg", mem_addr[9:8], 2'b10);
        page_op(5'h12);
        page_op(5'h11);
        check(mem_addr[9:8] == 2'b00, "R8 user to base", mem_addr[9:8], 0);
        // R9 pulses
        k0 = rb_cnt;
        ir_scan(5'h0D, c);
        check(rb_cnt == k0 + 1, "R9 reboot pulse width", rb_cnt - k0, 1);
        k0 = sv_cnt;
        ir_scan(5'h0E, c);
        check(sv_cnt == k0 + 1, "R9 save pulse width", sv_cnt - k0, 1);
        check(rb_cnt == 1, "R9 no reboot on save", rb_cnt, 1);
        // random mix
        for (int k = 0; k < 60; k++) begin
            int r = $urandom_range(0, 5);
            case (r)
                0: begin
                    logic [4:0] ops [4] = '{5'h10, 5'h11, 5'h12, 5'h13};
                    page_op(ops[$urandom_range(0, 3)]);
                end
                1: load_addr(8'($urandom));
                2: do_write(8'($urandom));
                3: do_read();
                4: begin
                    k0 = rb_cnt; ir_scan(5'h0D, c);
                    check(rb_cnt == k0 + 1, "R9 random reboot", rb_cnt - k0, 1);
                end
                default: begin
                    k0 = sv_cnt; ir_scan(5'h0E, c);
                    check(sv_cnt == k0 + 1, "R9 random save", sv_cnt - k0, 1);
                end
            endcase
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule